// File: doc/BRIEF.md
# Memory attribute indirection unit

This block keeps the attribute indirection table that a stage-1 address translation consults when a long-format translation entry carries a 3-bit attribute index. The table is held as two 32-bit registers. Each register packs four 8-bit attribute codes, so the pair holds eight codes, one for each index value. A secure copy and a non-secure copy of the pair exist side by side. Software reaches them through a simple register-access port. That port checks privilege, routes each access to the bank named by its security input, and drops secure-bank writes while a hardware lock input is held high.

On the lookup side, the translation logic presents an index and a security state. It receives the selected 8-bit code already decoded into a memory kind, a device subtype, outer and inner cacheability, read and write allocate hints, and a flag that marks reserved encodings. The decode is combinational from the stored registers. A register write is therefore seen by lookups from the cycle after the write edge.

Top module: `attr_indir_unit`

## Requirements
- R1: After reset all four registers hold zero: every permitted read returns 0, and every lookup in either bank reports device memory of subtype 0 with unpred 0.
- R2: A lookup with index n returns the decode of bits [8n+7:8n] of {register 1, register 0}. Index bit 2 therefore selects register 1 when high. A write is seen by a lookup presented in the next cycle.
- R3: An access with acc_secure=1 targets the secure bank, and with acc_secure=0 the non-secure bank. A lookup with lk_secure=1 reads the secure bank, and otherwise the non-secure bank. A write to one bank leaves the other unchanged.
- R4: While sec_wr_lock is 1, writes with acc_secure=1 leave the secure bank unchanged and raise no error. Non-secure writes still complete, and secure reads still return data.
- R5: An access (acc_rd or acc_wr) with acc_el=0 raises acc_err in the next cycle only, changes no register and returns 0 on acc_rdata. Levels 1 to 3 read and write without error.
- R6: acc_rdata presents the register chosen by acc_secure and acc_sel in the cycle after a permitted read, and is 0 in any cycle that does not follow a permitted read.
- R7: An upper nibble of 0000 gives lk_normal=0 and lk_dev_kind = lower nibble bits [3:2]. The subtype codes are 0 for non-gathering/non-reordering/no early ack, 1 for non-gathering/non-reordering/early ack, 2 for non-gathering/reordering/early ack and 3 for gathering/reordering/early ack. Both policies are 0 and all allocate hints are 0. lk_unpred=1 exactly when lower nibble bits [1:0] are non-zero.
- R8: For a non-zero upper nibble, lk_normal=1 and lk_dev_kind=0. The upper nibble sets lk_outer_pol and the lower nibble sets lk_inner_pol. The policy codes are: 0100 gives 1 (non-cacheable); 00RW or 10RW gives 2 (write-through); 01RW or 11RW gives 3 (write-back). The transient bit is ignored.
- R9: For a nibble that decodes to policy 2 or 3, the read-allocate hint is nibble bit 1 and the write-allocate hint is nibble bit 0. For every other nibble both hints are 0.
- R10: A non-zero upper nibble with a lower nibble of 0000 gives lk_unpred=1, lk_inner_pol=0 and inner hints 0. Every other normal encoding gives lk_unpred=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_rd | input | 1 | Register read request |
| acc_wr | input | 1 | Register write request |
| acc_sel | input | 1 | Register select: 0 = register 0, 1 = register 1 |
| acc_el | input | 2 | Privilege level of the access, 0 = lowest |
| acc_secure | input | 1 | Security state of the access, 1 = secure bank |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, one cycle after the read |
| acc_err | output | 1 | One-cycle pulse for a refused access |
| sec_wr_lock | input | 1 | Drops secure-bank writes while high |
| lk_secure | input | 1 | Security state of the lookup |
| lk_idx | input | 3 | Attribute index from the translation entry |
| lk_normal | output | 1 | 1 = normal memory, 0 = device |
| lk_dev_kind | output | 2 | Device subtype code |
| lk_outer_pol | output | 2 | Outer policy: 0 none, 1 non-cacheable, 2 write-through, 3 write-back |
| lk_inner_pol | output | 2 | Inner policy, same codes |
| lk_outer_ra | output | 1 | Outer read-allocate hint |
| lk_outer_wa | output | 1 | Outer write-allocate hint |
| lk_inner_ra | output | 1 | Inner read-allocate hint |
| lk_inner_wa | output | 1 | Inner write-allocate hint |
| lk_unpred | output | 1 | Reserved encoding flag |

## Verification
The bench builds the unit with its default parameters: 32-bit registers, two registers per bank and 8-bit fields. With these values the full 3-bit index space and the bank boundary at index bit 2 are exercised. A sweep writes every one of the 256 byte codes into the table, so every device subtype, every policy nibble, both transient forms and every reserved combination are decoded at least once. The same default widths keep the privilege, lock and banking sequences short enough to run in both banks with both register selects.

// File: rtl/attr_indir_pkg.sv
package attr_indir_pkg;

    localparam int unsigned ATTR_FIELD_W = 8;
    localparam int unsigned ATTR_NIB_W   = ATTR_FIELD_W / 2;

    typedef enum logic [1:0] {
        CP_NONE = 2'd0,
        CP_NC   = 2'd1,
        CP_WT   = 2'd2,
        CP_WB   = 2'd3
    } cache_pol_e;

    typedef enum logic [1:0] {
        DV_NG_NR_NE = 2'd0,
        DV_NG_NR_E  = 2'd1,
        DV_NG_R_E   = 2'd2,
        DV_G_R_E    = 2'd3
    } dev_kind_e;

    typedef struct packed {
        logic       normal;
        dev_kind_e  dev_kind;
        cache_pol_e outer_pol;
        cache_pol_e inner_pol;
        logic       outer_ra;
        logic       outer_wa;
        logic       inner_ra;
        logic       inner_wa;
        logic       unpred;
    } attr_dec_t;

    // Policy carried by one nibble of a normal-memory code.
    function automatic cache_pol_e nib_policy(input logic [ATTR_NIB_W-1:0] n);
        cache_pol_e p;
        if (n == 4'b0000)      p = CP_NONE;
        else if (n == 4'b0100) p = CP_NC;
        else if (n[2])         p = CP_WB;
        else                   p = CP_WT;
        return p;
    endfunction

    // Allocate hints {read, write}; only cacheable policies carry them.
    function automatic logic [1:0] nib_alloc(input logic [ATTR_NIB_W-1:0] n);
        cache_pol_e p;
        p = nib_policy(n);
        return ((p == CP_WT) || (p == CP_WB)) ? n[1:0] : 2'b00;
    endfunction

endpackage

// File: rtl/attr_access_gate.sv
module attr_access_gate #(
    parameter int unsigned EL_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_rd,
    input  logic            acc_wr,
    input  logic [EL_W-1:0] acc_el,
    input  logic            acc_secure,
    input  logic            sec_wr_lock,
    output logic            rd_ok,
    output logic [1:0]      bank_we,
    output logic            err_q
);
    logic denied;
    logic wr_ok;

    always_comb begin
        denied  = (acc_rd || acc_wr) && (acc_el == '0);
        rd_ok   = acc_rd && !denied;
        wr_ok   = acc_wr && !denied && !(acc_secure && sec_wr_lock);
        bank_we = {wr_ok && acc_secure, wr_ok && !acc_secure};
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= denied;
    end
endmodule

// File: rtl/attr_reg_bank.sv
module attr_reg_bank #(
    parameter int unsigned REG_W    = 32,
    parameter int unsigned NUM_REGS = 2,
    parameter int unsigned SEL_W    = 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [SEL_W-1:0]                   wr_sel,
    input  logic [REG_W-1:0]                   wr_data,
    output logic [NUM_REGS-1:0][REG_W-1:0]     regs
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic [REG_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr_en && (wr_sel == SEL_W'(r)))
                q <= wr_data;
        end
        assign regs[r] = q;
    end
endmodule

// File: rtl/attr_field_select.sv
module attr_field_select #(
    parameter int unsigned REG_W    = 32,
    parameter int unsigned NUM_REGS = 2,
    parameter int unsigned FIELD_W  = 8,
    parameter int unsigned IDX_W    = 3
) (
    input  logic [NUM_REGS-1:0][REG_W-1:0] regs,
    input  logic [IDX_W-1:0]               idx,
    output logic [FIELD_W-1:0]             field
);
    localparam int unsigned FLAT_W = NUM_REGS * REG_W;
    logic [FLAT_W-1:0] flat;

    always_comb begin
        flat  = regs;
        field = flat[int'(idx) * FIELD_W +: FIELD_W];
    end
endmodule

// File: rtl/attr_field_decode.sv
module attr_field_decode
    import attr_indir_pkg::*;
(
    input  logic [ATTR_FIELD_W-1:0] field,
    output attr_dec_t               dec
);
    logic [ATTR_NIB_W-1:0] hi;
    logic [ATTR_NIB_W-1:0] lo;

    always_comb begin
        hi  = field[ATTR_FIELD_W-1:ATTR_NIB_W];
        lo  = field[ATTR_NIB_W-1:0];
        dec = '0;
        if (hi == '0) begin
            dec.normal   = 1'b0;
            dec.dev_kind = dev_kind_e'(lo[3:2]);
            dec.unpred   = (lo[1:0] != 2'b00);
        end else begin
            dec.normal                   = 1'b1;
            dec.outer_pol                = nib_policy(hi);
            {dec.outer_ra, dec.outer_wa} = nib_alloc(hi);
            dec.inner_pol                = nib_policy(lo);
            {dec.inner_ra, dec.inner_wa} = nib_alloc(lo);
            dec.unpred                   = (lo == '0);
        end
    end
endmodule

// File: rtl/attr_indir_unit.sv
module attr_indir_unit
    import attr_indir_pkg::*;
#(
    parameter int unsigned REG_W    = 32,
    parameter int unsigned NUM_REGS = 2,
    parameter int unsigned EL_W     = 2,
    localparam int unsigned FIELDS  = NUM_REGS * (REG_W / ATTR_FIELD_W),
    localparam int unsigned IDX_W   = $clog2(FIELDS),
    localparam int unsigned SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_rd,
    input  logic             acc_wr,
    input  logic [SEL_W-1:0] acc_sel,
    input  logic [EL_W-1:0]  acc_el,
    input  logic             acc_secure,
    input  logic [REG_W-1:0] acc_wdata,
    output logic [REG_W-1:0] acc_rdata,
    output logic             acc_err,
    input  logic             sec_wr_lock,
    input  logic             lk_secure,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_normal,
    output logic [1:0]       lk_dev_kind,
    output logic [1:0]       lk_outer_pol,
    output logic [1:0]       lk_inner_pol,
    output logic             lk_outer_ra,
    output logic             lk_outer_wa,
    output logic             lk_inner_ra,
    output logic             lk_inner_wa,
    output logic             lk_unpred
);
    localparam int unsigned NUM_BANKS = 2;   // index 0 non-secure, 1 secure

    logic                                          rd_ok;
    logic [NUM_BANKS-1:0]                          bank_we;
    logic [NUM_BANKS-1:0][NUM_REGS-1:0][REG_W-1:0] bank_q;
    logic [NUM_REGS-1:0][REG_W-1:0]                lk_regs;
    logic [ATTR_FIELD_W-1:0]                       lk_field;
    logic [REG_W-1:0]                              rd_word;
    logic [REG_W-1:0]                              rdata_q;
    attr_dec_t                                     dec;

    attr_access_gate #(.EL_W(EL_W)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .acc_rd     (acc_rd),
        .acc_wr     (acc_wr),
        .acc_el     (acc_el),
        .acc_secure (acc_secure),
        .sec_wr_lock(sec_wr_lock),
        .rd_ok      (rd_ok),
        .bank_we    (bank_we),
        .err_q      (acc_err)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        attr_reg_bank #(
            .REG_W   (REG_W),
            .NUM_REGS(NUM_REGS),
            .SEL_W   (SEL_W)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (bank_we[b]),
            .wr_sel (acc_sel),
            .wr_data(acc_wdata),
            .regs   (bank_q[b])
        );
    end

    // Read path: registered, zero unless a permitted read was presented.
    always_comb begin
        rd_word = '0;
        if (int'(acc_sel) < NUM_REGS)
            rd_word = bank_q[acc_secure][acc_sel];
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_ok) rdata_q <= rd_word;
        else            rdata_q <= '0;
    end
    assign acc_rdata = rdata_q;

    // Lookup path: combinational from the stored bank.
    assign lk_regs = bank_q[lk_secure];

    attr_field_select #(
        .REG_W   (REG_W),
        .NUM_REGS(NUM_REGS),
        .FIELD_W (ATTR_FIELD_W),
        .IDX_W   (IDX_W)
    ) u_sel (
        .regs (lk_regs),
        .idx  (lk_idx),
        .field(lk_field)
    );

    attr_field_decode u_dec (
        .field(lk_field),
        .dec  (dec)
    );

    assign lk_normal    = dec.normal;
    assign lk_dev_kind  = dec.dev_kind;
    assign lk_outer_pol = dec.outer_pol;
    assign lk_inner_pol = dec.inner_pol;
    assign lk_outer_ra  = dec.outer_ra;
    assign lk_outer_wa  = dec.outer_wa;
    assign lk_inner_ra  = dec.inner_ra;
    assign lk_inner_wa  = dec.inner_wa;
    assign lk_unpred    = dec.unpred;
endmodule

// File: rtl/attr_indir_chk.sv
module attr_indir_chk #(
    parameter int unsigned REG_W    = 32,
    parameter int unsigned NUM_REGS = 2,
    parameter int unsigned EL_W     = 2,
    parameter int unsigned SEL_W    = 1
) (
    input logic                                  clk,
    input logic                                  rst,
    input logic                                  acc_rd,
    input logic                                  acc_wr,
    input logic [SEL_W-1:0]                      acc_sel,
    input logic [EL_W-1:0]                       acc_el,
    input logic                                  acc_secure,
    input logic [REG_W-1:0]                      acc_wdata,
    input logic [REG_W-1:0]                      acc_rdata,
    input logic                                  acc_err,
    input logic                                  sec_wr_lock,
    input logic                                  lk_normal,
    input logic [1:0]                            lk_outer_pol,
    input logic [1:0]                            lk_inner_pol,
    input logic                                  lk_inner_ra,
    input logic                                  lk_inner_wa,
    input logic [1:0][NUM_REGS-1:0][REG_W-1:0]   bank_q
);
    a_r5_low_level_err: assert property (@(posedge clk) disable iff (rst)
        ((acc_rd || acc_wr) && (acc_el == '0)) |=> acc_err);

    a_r5_low_level_zero: assert property (@(posedge clk) disable iff (rst)
        ((acc_rd || acc_wr) && (acc_el == '0)) |=> (acc_rdata == '0));

    a_r5_priv_no_err: assert property (@(posedge clk) disable iff (rst)
        ((acc_rd || acc_wr) && (acc_el != '0)) |=> !acc_err);

    a_r4_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && acc_secure && sec_wr_lock) |=> (bank_q[1] == $past(bank_q[1])));

    a_r3_ns_write_lands: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && !acc_secure && (acc_el != '0))
            |=> (bank_q[0][$past(acc_sel)] == $past(acc_wdata)));

    a_r3_ns_write_spares_s: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && !acc_secure) |=> (bank_q[1] == $past(bank_q[1])));

    a_r7_device_no_policy: assert property (@(posedge clk) disable iff (rst)
        !lk_normal |-> (lk_outer_pol == 2'd0 && lk_inner_pol == 2'd0));

    a_r9_hints_need_cache: assert property (@(posedge clk) disable iff (rst)
        (lk_inner_pol < 2'd2) |-> (!lk_inner_ra && !lk_inner_wa));
endmodule

bind attr_indir_unit attr_indir_chk #(
    .REG_W   (REG_W),
    .NUM_REGS(NUM_REGS),
    .EL_W    (EL_W),
    .SEL_W   (SEL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_rd      (acc_rd),
    .acc_wr      (acc_wr),
    .acc_sel     (acc_sel),
    .acc_el      (acc_el),
    .acc_secure  (acc_secure),
    .acc_wdata   (acc_wdata),
    .acc_rdata   (acc_rdata),
    .acc_err     (acc_err),
    .sec_wr_lock (sec_wr_lock),
    .lk_normal   (lk_normal),
    .lk_outer_pol(lk_outer_pol),
    .lk_inner_pol(lk_inner_pol),
    .lk_inner_ra (lk_inner_ra),
    .lk_inner_wa (lk_inner_wa),
    .bank_q      (bank_q)
);

// File: tb/sim_attr_indir_unit.sv
`timescale 1ns/1ps
module sim_attr_indir_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_rd = 1'b0, acc_wr = 1'b0, acc_sel = 1'b0, acc_secure = 1'b0;
    logic [1:0]  acc_el = 2'd0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_err;
    logic        sec_wr_lock = 1'b0;
    logic        lk_secure = 1'b0;
    logic [2:0]  lk_idx = '0;
    logic        lk_normal, lk_outer_ra, lk_outer_wa, lk_inner_ra, lk_inner_wa, lk_unpred;
    logic [1:0]  lk_dev_kind, lk_outer_pol, lk_inner_pol;

    always #2 clk = ~clk;   // 250 MHz

    attr_indir_unit u0 (
        .clk(clk), .rst(rst), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_sel(acc_sel),
        .acc_el(acc_el), .acc_secure(acc_secure), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_err(acc_err), .sec_wr_lock(sec_wr_lock),
        .lk_secure(lk_secure), .lk_idx(lk_idx), .lk_normal(lk_normal),
        .lk_dev_kind(lk_dev_kind), .lk_outer_pol(lk_outer_pol), .lk_inner_pol(lk_inner_pol),
        .lk_outer_ra(lk_outer_ra), .lk_outer_wa(lk_outer_wa), .lk_inner_ra(lk_inner_ra),
        .lk_inner_wa(lk_inner_wa), .lk_unpred(lk_unpred)
    );

    // Scoreboard: kind 0 = read data, 1 = error flag, 2 = decoded lookup bundle.
    int          q_due[$];
    int          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] shadow [2][2];

    function automatic logic [1:0] pol_of(input logic [3:0] n);
        if (n == 4'h0) return 2'd0;
        if (n == 4'h4) return 2'd1;
        if (n[3:2] == 2'b01 || n[3:2] == 2'b11) return 2'd3;
        return 2'd2;
    endfunction

    // Bundle {normal, dev_kind, outer_pol, inner_pol, ora, owa, ira, iwa, unpred}
    function automatic logic [31:0] exp_bundle(input logic [7:0] f);
        logic [3:0] hi, lo;
        logic       nrm, unp;
        logic [1:0] dk, op, ip, oh, ih;
        hi = f[7:4]; lo = f[3:0];
        nrm = 1'b0; dk = 2'd0; op = 2'd0; ip = 2'd0; oh = 2'd0; ih = 2'd0; unp = 1'b0;
        if (hi == 4'h0) begin
            dk  = lo[3:2];
            unp = (lo[1:0] != 2'b00);
        end else begin
            nrm = 1'b1;
            op  = pol_of(hi);
            ip  = pol_of(lo);
            if (op >= 2'd2) oh = hi[1:0];
            if (ip >= 2'd2) ih = lo[1:0];
            unp = (lo == 4'h0);
        end
        return {19'd0, nrm, dk, op, ip, oh, ih, unp};
    endfunction

    function automatic logic [31:0] act_bundle();
        return {19'd0, lk_normal, lk_dev_kind, lk_outer_pol, lk_inner_pol,
                lk_outer_ra, lk_outer_wa, lk_inner_ra, lk_inner_wa, lk_unpred};
    endfunction

    task automatic push(input int kind, input logic [31:0] e, input string tag);
        q_due.push_back(cyc + 1);
        q_kind.push_back(kind);
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    task automatic drive(input logic rd, input logic wr, input logic sec, input logic sel,
                         input logic [1:0] el, input logic [31:0] d);
        acc_rd = rd; acc_wr = wr; acc_secure = sec; acc_sel = sel; acc_el = el; acc_wdata = d;
    endtask

    task automatic do_write(input logic sec, input logic sel, input logic [1:0] el,
                            input logic [31:0] d, input string tag);
        @(negedge clk);
        drive(1'b0, 1'b1, sec, sel, el, d);
        push(1, {31'd0, (el == 2'd0)}, tag);
        if (el != 2'd0 && !(sec && sec_wr_lock)) shadow[sec][sel] = d;
    endtask

    task automatic do_read(input logic sec, input logic sel, input logic [1:0] el,
                           input string tag);
        @(negedge clk);
        drive(1'b1, 1'b0, sec, sel, el, '0);
        push(1, {31'd0, (el == 2'd0)}, tag);
        push(0, (el == 2'd0) ? 32'd0 : shadow[sec][sel], tag);
    endtask

    task automatic do_look(input logic sec, input logic [2:0] idx, input string tag);
        logic [63:0] flat;
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 2'd1, '0);
        lk_secure = sec; lk_idx = idx;
        flat = {shadow[sec][1], shadow[sec][0]};
        push(2, exp_bundle(flat[int'(idx)*8 +: 8]), tag);
        push(0, 32'd0, tag);    // no read pending: read data must be zero
    endtask

    // Monitor: compares due items just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #1;
            while (q_due.size() > 0 && q_due[0] <= cyc) begin
                int          k;
                logic [31:0] e, a;
                string       t;
                k = q_kind.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
                void'(q_due.pop_front());
                a = (k == 0) ? acc_rdata : (k == 1) ? {31'd0, acc_err} : act_bundle();
                n_chk++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, a, e);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++) for (int r = 0; r < 2; r++) shadow[b][r] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of both banks
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 2; r++) do_read(b[0], r[0], 2'd1, "R1 reset read");
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 8; i++) do_look(b[0], i[2:0], "R1 reset lookup");

        // R2 R7 R8 R9 R10: every byte code through every index position
        for (int v = 0; v < 64; v++) begin
            logic [7:0] b0;
            b0 = 8'(4 * v);
            do_write(1'b0, 1'b0, 2'd1, {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0}, "R2 fill r0");
            do_write(1'b0, 1'b1, 2'd1, {b0 + 8'd131, b0 + 8'd130, b0 + 8'd129, b0 + 8'd128},
                     "R2 fill r1");
            for (int i = 0; i < 8; i++) do_look(1'b0, i[2:0], "R8 R9 R10 decode sweep");
        end
        // R7: device subtypes and reserved device codes placed by index
        do_write(1'b0, 1'b0, 2'd2, 32'h0C_08_04_00, "R7 dev fill");
        do_write(1'b0, 1'b1, 2'd3, 32'h0F_0A_05_01, "R7 dev fill");
        for (int i = 0; i < 8; i++) do_look(1'b0, i[2:0], "R7 device decode");
        do_read(1'b0, 1'b1, 2'd2, "R6 read level 2");

        // R3: secure bank independent of non-secure bank
        do_write(1'b1, 1'b0, 2'd3, 32'hFF_44_BB_AA, "R3 secure write");
        do_write(1'b1, 1'b1, 2'd1, 32'h04_0C_77_EE, "R3 secure write");
        for (int i = 0; i < 8; i++) do_look(1'b1, i[2:0], "R3 secure lookup");
        for (int i = 0; i < 8; i++) do_look(1'b0, i[2:0], "R3 ns lookup unchanged");
        do_read(1'b1, 1'b0, 2'd1, "R3 R6 secure read");
        do_read(1'b0, 1'b0, 2'd1, "R3 R6 ns read");

        // R4: lock drops secure writes only
        @(negedge clk); sec_wr_lock = 1'b1;
        do_write(1'b1, 1'b0, 2'd3, 32'h12345678, "R4 locked secure write");
        do_read(1'b1, 1'b0, 2'd3, "R4 secure unchanged");
        do_look(1'b1, 3'd0, "R4 secure lookup unchanged");
        do_write(1'b0, 1'b1, 2'd1, 32'h99_88_77_66, "R4 ns write under lock");
        do_read(1'b0, 1'b1, 2'd1, "R4 ns write landed");
        @(negedge clk); sec_wr_lock = 1'b0;
        do_write(1'b1, 1'b0, 2'd3, 32'h12345678, "R4 unlocked secure write");
        do_read(1'b1, 1'b0, 2'd3, "R4 secure write landed");

        // R5: lowest level refused in both states
        do_write(1'b0, 1'b0, 2'd0, 32'hDEADBEEF, "R5 el0 ns write");
        do_read(1'b0, 1'b0, 2'd1, "R5 ns unchanged");
        do_write(1'b1, 1'b1, 2'd0, 32'hCAFEF00D, "R5 el0 s write");
        do_read(1'b1, 1'b1, 2'd2, "R5 s unchanged");
        do_read(1'b1, 1'b0, 2'd0, "R5 el0 s read");
        do_read(1'b0, 1'b1, 2'd0, "R5 el0 ns read");
        do_look(1'b0, 3'd5, "R5 R6 idle after refusal");

        @(negedge clk); drive(1'b0, 1'b0, 1'b0, 1'b0, 2'd1, '0);
        repeat (3) @(negedge clk);
        if (q_due.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard residue actual=%0d expected=0", q_due.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule